// File: doc/BRIEF.md
# Two-Pass Separable Sub-Pixel Interpolator

This block builds one 8x8 block of predicted pixels at a fractional position in both directions. It is used when the horizontal and vertical quarter-pel modes are both nonzero. A caller first sends a start pulse with the two modes, a rounding control bit and an averaging flag. It then streams eleven source rows, each eleven pixels wide, one row per accepted cycle. The rows span one line above the block to two lines below it. The columns span one pixel left of the block to two pixels right of it.

The first pass keeps a window of the last four source rows. With each row that completes a window, it produces one 11-entry row of signed 16-bit intermediate values. The second pass is a single-row stage placed directly behind the first, so horizontal filtering of row k overlaps with vertical filtering of row k+1. The second pass applies the horizontal kernel, rounds, shifts by seven and clips to 8 bits. In averaging mode it then blends the result with the destination row that arrived together with the source row that completed the window.

Three four-tap kernels are selected by mode:

| Mode | Taps |
|------|------|
| 1 | (-4, 53, 18, -3) |
| 2 | (-1, 9, 9, -1) |
| 3 | (-3, 18, 53, -4) |

The first-pass shift is derived from a per-mode table.

Top module: `subpel_2d_interp`

## Requirements
- R1: After reset, `busy`, `out_valid` and `done` are low.
- R2: A `start` pulse while idle, with `hmode` and `vmode` both in 1..3, latches the modes, `rnd` and `avg` and raises `busy`. Later changes on those inputs do not affect the block in progress.
- R3: A `start` with `hmode` or `vmode` equal to 0 is ignored. `busy` stays low and no rows are produced.
- R4: Source row i is the i-th accepted row, covering lines y-1 .. y+9. Intermediate row k, column c is computed from source rows k..k+3 at column c:
  - Multiply by the `vmode` taps in row order and sum.
  - Add (1<<(s-1)) + rnd - 1, then shift arithmetically right by s.
  - s = (t[hmode] + t[vmode]) >> 1, where the per-mode table t is {0, 5, 1, 5} for modes 0, 1, 2, 3.
  - Keep the result as a signed 16-bit value.
- R5: Output pixel j of a row is computed from intermediate columns j..j+3:
  - Multiply by the `hmode` taps in column order and sum.
  - Add 64 - rnd, shift arithmetically right by 7, and clip to 0..255.
- R6: With `avg` latched high, each output pixel becomes (p + d + 1) >> 1. Here p is the clipped value and d is the same-position pixel of `dst_row`. `dst_row` is sampled with source row k+3, which belongs to output row k.
- R7: Output row k appears with `out_valid` high after the second rising edge following acceptance of source row k+3. Gaps in `src_valid` delay it accordingly.
- R8: `done` is high together with the eighth output row only, once per block. `busy` is low in the following cycle. Source rows beyond the eleventh are not accepted.
- R9: `src_valid` while idle has no effect. No output row is produced.
- R10: A `start` while `busy` is high is ignored. The running block completes with its latched settings.
- R11: Pixel c of `src_row` sits at bits [8c+7:8c]. Output pixel j sits at bits [8j+7:8j] of `out_row`, and likewise for `dst_row`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a block with the presented settings |
| hmode | input | 2 | Horizontal quarter-pel mode, 1..3 |
| vmode | input | 2 | Vertical quarter-pel mode, 1..3 |
| rnd | input | 1 | Rounding control |
| avg | input | 1 | Blend results into destination pixels |
| src_valid | input | 1 | Source row present |
| src_row | input | 88 | Eleven 8-bit source pixels |
| dst_row | input | 64 | Eight destination pixels for averaging |
| busy | output | 1 | A block is in progress |
| out_valid | output | 1 | Output row valid |
| out_row | output | 64 | Eight interpolated pixels |
| done | output | 1 | Last output row of the block |

## Verification
A corrupted source window or a wrong tap shows up in the very next output row, two edges after the offending source row. A wrong shift or rounder latched at start skews every pixel of all eight rows by a small, data-dependent amount. The bench therefore compares every pixel against an arithmetic model, using patterns that reach both clip limits. A control fault, such as a miscounted row index or an early or late `done`, shows up at the ports as a missing, extra or time-shifted `out_valid`. The bench compares the cycle of each output row against the cycle of its triggering source row.

// File: rtl/subpel_pkg.sv
package subpel_pkg;
  localparam int PIX_W = 8;
  localparam int TAPS  = 4;

  // Tap weight t (0 = earliest row/column) for a quarter-pel mode.
  function automatic int tap_coef(input logic [1:0] mode, input int t);
    case (mode)
      2'd1: case (t) 0: return -4; 1: return 53; 2: return 18; default: return -3; endcase
      2'd2: case (t) 0: return -1; 1: return 9;  2: return 9;  default: return -1; endcase
      2'd3: case (t) 0: return -3; 1: return 18; 2: return 53; default: return -4; endcase
      default: return 0;
    endcase
  endfunction

  function automatic int mode_weight(input logic [1:0] mode);
    case (mode)
      2'd1: return 5;
      2'd2: return 1;
      2'd3: return 5;
      default: return 0;
    endcase
  endfunction

  function automatic int pass1_shift(input logic [1:0] h, input logic [1:0] v);
    return (mode_weight(h) + mode_weight(v)) >> 1;
  endfunction

  function automatic int pass1_round(input int sum, input int sh, input logic r);
    if (sh == 0) return sum;
    return (sum + (1 << (sh - 1)) + int'(r) - 1) >>> sh;
  endfunction

  function automatic int pass2_round(input int sum, input logic r);
    return (sum + 64 - int'(r)) >>> 7;
  endfunction

  function automatic logic [PIX_W-1:0] clip_pix(input int v);
    if (v < 0) return '0;
    if (v > (1 << PIX_W) - 1) return '1;
    return v[PIX_W-1:0];
  endfunction

  function automatic logic [PIX_W-1:0] blend_pix(input logic [PIX_W-1:0] a,
                                                 input logic [PIX_W-1:0] b);
    logic [PIX_W:0] s;
    s = {1'b0, a} + {1'b0, b} + {{PIX_W{1'b0}}, 1'b1};
    return s[PIX_W:1];
  endfunction
endpackage

// File: rtl/subpel_ctrl.sv
module subpel_ctrl
  import subpel_pkg::*;
#(
  parameter int ROWS = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [1:0]                 hmode,
  input  logic [1:0]                 vmode,
  input  logic                       rnd,
  input  logic                       avg,
  input  logic                       src_valid,
  input  logic                       done_in,
  output logic                       busy,
  output logic                       cfg_load,
  output logic                       accept,
  output logic                       last_in,
  output logic [$clog2(ROWS+3)-1:0]  row_idx,
  output logic [1:0]                 cfg_h,
  output logic [1:0]                 cfg_v,
  output logic                       cfg_rnd,
  output logic                       cfg_avg,
  output logic [2:0]                 cfg_shift
);
  localparam int SRC_ROWS = ROWS + TAPS - 1;
  localparam int IDX_W    = $clog2(SRC_ROWS);

  logic       fed_all;
  logic [2:0] shift_d;
  int         shift_i;

  always_comb begin
    shift_i = pass1_shift(hmode, vmode);
    shift_d = shift_i[2:0];
  end

  assign cfg_load = start && !busy && (hmode != 2'd0) && (vmode != 2'd0);
  assign accept   = busy && !fed_all && src_valid;
  assign last_in  = accept && (row_idx == IDX_W'(SRC_ROWS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      fed_all   <= 1'b0;
      row_idx   <= '0;
      cfg_h     <= '0;
      cfg_v     <= '0;
      cfg_rnd   <= 1'b0;
      cfg_avg   <= 1'b0;
      cfg_shift <= '0;
    end else if (cfg_load) begin
      busy      <= 1'b1;
      fed_all   <= 1'b0;
      row_idx   <= '0;
      cfg_h     <= hmode;
      cfg_v     <= vmode;
      cfg_rnd   <= rnd;
      cfg_avg   <= avg;
      cfg_shift <= shift_d;
    end else begin
      if (done_in) busy <= 1'b0;
      if (last_in) begin
        fed_all <= 1'b1;
        row_idx <= '0;
      end else if (accept) begin
        row_idx <= row_idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/subpel_vpass.sv
module subpel_vpass
  import subpel_pkg::*;
#(
  parameter int COLS  = 8,
  parameter int ROWS  = 8,
  parameter int MID_W = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              accept,
  input  logic                              last_in,
  input  logic [$clog2(ROWS+3)-1:0]         row_idx,
  input  logic [1:0]                        vmode,
  input  logic [2:0]                        shift,
  input  logic                              rnd,
  input  logic [(COLS+3)*PIX_W-1:0]         src_row,
  input  logic [COLS*PIX_W-1:0]             dst_row,
  output logic                              mid_valid,
  output logic                              mid_last,
  output logic [(COLS+3)*MID_W-1:0]         mid_row,
  output logic [COLS*PIX_W-1:0]             mid_dst
);
  localparam int SRC_COLS = COLS + TAPS - 1;
  localparam int IDX_W    = $clog2(ROWS + TAPS - 1);
  localparam int ROW_W    = SRC_COLS * PIX_W;

  logic [ROW_W-1:0]          win0, win1, win2;
  logic [SRC_COLS*MID_W-1:0] mid_next;
  logic                      window_full;

  assign window_full = row_idx >= IDX_W'(TAPS - 1);

  for (genvar c = 0; c < SRC_COLS; c++) begin : g_col
    int acc;
    int res;
    always_comb begin
      acc = tap_coef(vmode, 0) * int'(win0[c*PIX_W +: PIX_W])
          + tap_coef(vmode, 1) * int'(win1[c*PIX_W +: PIX_W])
          + tap_coef(vmode, 2) * int'(win2[c*PIX_W +: PIX_W])
          + tap_coef(vmode, 3) * int'(src_row[c*PIX_W +: PIX_W]);
      res = pass1_round(acc, int'(shift), rnd);
    end
    assign mid_next[c*MID_W +: MID_W] = res[MID_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win0      <= '0;
      win1      <= '0;
      win2      <= '0;
      mid_valid <= 1'b0;
      mid_last  <= 1'b0;
      mid_row   <= '0;
      mid_dst   <= '0;
    end else begin
      mid_valid <= accept && window_full;
      mid_last  <= last_in;
      if (accept) begin
        win0 <= win1;
        win1 <= win2;
        win2 <= src_row;
        if (window_full) begin
          mid_row <= mid_next;
          mid_dst <= dst_row;
        end
      end
    end
  end
endmodule

// File: rtl/subpel_hpass.sv
module subpel_hpass
  import subpel_pkg::*;
#(
  parameter int COLS  = 8,
  parameter int MID_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        mid_valid,
  input  logic                        mid_last,
  input  logic [(COLS+3)*MID_W-1:0]   mid_row,
  input  logic [COLS*PIX_W-1:0]       mid_dst,
  input  logic [1:0]                  hmode,
  input  logic                        rnd,
  input  logic                        avg,
  output logic                        out_valid,
  output logic [COLS*PIX_W-1:0]       out_row,
  output logic                        done
);
  logic [COLS*PIX_W-1:0] row_next;

  for (genvar j = 0; j < COLS; j++) begin : g_pix
    int                acc;
    logic [PIX_W-1:0]  clipped;
    always_comb begin
      acc = 0;
      for (int t = 0; t < TAPS; t++)
        acc += tap_coef(hmode, t) * int'(signed'(mid_row[(j+t)*MID_W +: MID_W]));
      clipped = clip_pix(pass2_round(acc, rnd));
    end
    assign row_next[j*PIX_W +: PIX_W] =
      avg ? blend_pix(clipped, mid_dst[j*PIX_W +: PIX_W]) : clipped;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      done      <= 1'b0;
      out_row   <= '0;
    end else begin
      out_valid <= mid_valid;
      done      <= mid_valid && mid_last;
      if (mid_valid) out_row <= row_next;
    end
  end
endmodule

// File: rtl/subpel_2d_interp.sv
module subpel_2d_interp
  import subpel_pkg::*;
#(
  parameter int COLS  = 8,
  parameter int ROWS  = 8,
  parameter int MID_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [1:0]                    hmode,
  input  logic [1:0]                    vmode,
  input  logic                          rnd,
  input  logic                          avg,
  input  logic                          src_valid,
  input  logic [(COLS+3)*PIX_W-1:0]     src_row,
  input  logic [COLS*PIX_W-1:0]         dst_row,
  output logic                          busy,
  output logic                          out_valid,
  output logic [COLS*PIX_W-1:0]         out_row,
  output logic                          done
);
  localparam int IDX_W = $clog2(ROWS + TAPS - 1);

  logic                         cfg_load, accept, last_in;
  logic [IDX_W-1:0]             row_idx;
  logic [1:0]                   cfg_h, cfg_v;
  logic                         cfg_rnd, cfg_avg;
  logic [2:0]                   cfg_shift;
  logic                         mid_valid, mid_last;
  logic [(COLS+3)*MID_W-1:0]    mid_row;
  logic [COLS*PIX_W-1:0]        mid_dst;

  subpel_ctrl #(.ROWS(ROWS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .hmode(hmode), .vmode(vmode),
    .rnd(rnd), .avg(avg), .src_valid(src_valid), .done_in(done),
    .busy(busy), .cfg_load(cfg_load), .accept(accept), .last_in(last_in),
    .row_idx(row_idx), .cfg_h(cfg_h), .cfg_v(cfg_v), .cfg_rnd(cfg_rnd),
    .cfg_avg(cfg_avg), .cfg_shift(cfg_shift)
  );

  subpel_vpass #(.COLS(COLS), .ROWS(ROWS), .MID_W(MID_W)) u_vpass (
    .clk(clk), .rst_n(rst_n), .accept(accept), .last_in(last_in),
    .row_idx(row_idx), .vmode(cfg_v), .shift(cfg_shift), .rnd(cfg_rnd),
    .src_row(src_row), .dst_row(dst_row), .mid_valid(mid_valid),
    .mid_last(mid_last), .mid_row(mid_row), .mid_dst(mid_dst)
  );

  subpel_hpass #(.COLS(COLS), .MID_W(MID_W)) u_hpass (
    .clk(clk), .rst_n(rst_n), .mid_valid(mid_valid), .mid_last(mid_last),
    .mid_row(mid_row), .mid_dst(mid_dst), .hmode(cfg_h), .rnd(cfg_rnd),
    .avg(cfg_avg), .out_valid(out_valid), .out_row(out_row), .done(done)
  );
endmodule

// File: rtl/subpel_2d_interp_chk.sv
module subpel_2d_interp_chk #(
  parameter int ROWS = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [1:0] hmode,
  input logic [1:0] vmode,
  input logic       src_valid,
  input logic       busy,
  input logic       cfg_load,
  input logic       mid_valid,
  input logic       out_valid,
  input logic       done,
  input logic [1:0] cfg_h,
  input logic [1:0] cfg_v
);
  logic [7:0] rows_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rows_seen <= '0;
    else if (cfg_load)  rows_seen <= '0;
    else if (out_valid) rows_seen <= rows_seen + 1'b1;
  end

  p_zero_mode_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (hmode == 2'd0 || vmode == 2'd0)) |=> !busy);

  p_cfg_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cfg_load) |=> (!busy || ($stable(cfg_h) && $stable(cfg_v))));

  p_row_follows_mid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mid_valid |=> out_valid);

  p_row_needs_mid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(mid_valid));

  p_done_with_row_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (out_valid && rows_seen == 8'(ROWS - 1)));

  p_idle_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  p_idle_rows_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && src_valid) |=> !mid_valid);
endmodule

bind subpel_2d_interp subpel_2d_interp_chk #(.ROWS(ROWS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .hmode(hmode), .vmode(vmode),
  .src_valid(src_valid), .busy(busy), .cfg_load(cfg_load),
  .mid_valid(mid_valid), .out_valid(out_valid), .done(done),
  .cfg_h(cfg_h), .cfg_v(cfg_v)
);

// File: tb/subpel_2d_interp_bench.sv
`timescale 1ns/1ps
module subpel_2d_interp_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  hmode = 2'd0;
  logic [1:0]  vmode = 2'd0;
  logic        rnd = 1'b0;
  logic        avg = 1'b0;
  logic        src_valid = 1'b0;
  logic [87:0] src_row = '0;
  logic [63:0] dst_row = '0;
  logic        busy, out_valid, done;
  logic [63:0] out_row;

  always #2.5 clk = ~clk;

  subpel_2d_interp u_subpel_2d_interp (
    .clk(clk), .rst_n(rst_n), .start(start), .hmode(hmode), .vmode(vmode),
    .rnd(rnd), .avg(avg), .src_valid(src_valid), .src_row(src_row),
    .dst_row(dst_row), .busy(busy), .out_valid(out_valid), .out_row(out_row),
    .done(done)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int cyc = 0;
  int out_tot = 0;
  int done_tot = 0;
  int done_idx = 0;
  logic [63:0] got [64];
  int got_cyc [64];

  int src_px [11][11];
  int dst_px [8][8];
  int acc_cyc [11];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (out_valid) begin
      got[out_tot % 64]     = out_row;
      got_cyc[out_tot % 64] = cyc;
      out_tot++;
    end
    if (done) begin
      done_tot++;
      done_idx = out_tot;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Model, written from the requirements.
  function automatic int kern(input int m, input int t);
    int k [4][4] = '{'{0, 0, 0, 0}, '{-4, 53, 18, -3}, '{-1, 9, 9, -1}, '{-3, 18, 53, -4}};
    return k[m][t];
  endfunction

  function automatic int model_pix(input int h, input int v, input int r,
                                   input int a, input int k, input int j);
    int sv [4] = '{0, 5, 1, 5};
    int s = (sv[h] + sv[v]) / 2;
    int mid [4];
    int sum2 = 0;
    int p;
    for (int t = 0; t < 4; t++) begin
      int sum1 = 0;
      for (int q = 0; q < 4; q++) sum1 += kern(v, q) * src_px[k+q][j+t];
      mid[t] = (sum1 + (1 << (s - 1)) + r - 1) >>> s;
      mid[t] = int'(16'(mid[t]));
      mid[t] = (mid[t] >= 32768) ? mid[t] - 65536 : mid[t];
    end
    for (int t = 0; t < 4; t++) sum2 += kern(h, t) * mid[t];
    p = (sum2 + 64 - r) >>> 7;
    if (p < 0) p = 0;
    if (p > 255) p = 255;
    if (a != 0) p = (p + dst_px[k][j] + 1) / 2;
    return p;
  endfunction

  function automatic void fill(input int pat);
    for (int y = 0; y < 11; y++)
      for (int x = 0; x < 11; x++)
        case (pat)
          1:       src_px[y][x] = 255;
          2:       src_px[y][x] = ((x + y) % 2 == 0) ? 255 : 0;
          3:       src_px[y][x] = (x % 2 == 0) ? 0 : 255;
          default: src_px[y][x] = int'($urandom_range(0, 255));
        endcase
    for (int y = 0; y < 8; y++)
      for (int x = 0; x < 8; x++) dst_px[y][x] = int'($urandom_range(0, 255));
  endfunction

  // One block, checked against the model: R2, R4, R5, R6, R7, R8, R10, R11.
  task automatic run_block(input int h, input int v, input int r, input int a,
                           input int pat, input int gap, input bit poke, input string req);
    int base = out_tot;
    int d0 = done_tot;
    bit timing_ok = 1;
    fill(pat);
    @(negedge clk);
    hmode = 2'(h); vmode = 2'(v); rnd = 1'(r); avg = 1'(a); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    hmode = 2'(3 - h + 1 > 3 ? 1 : 3 - h + 1); vmode = 2'd0; rnd = ~rnd; avg = ~avg;
    for (int i = 0; i < 11; i++) begin
      if (gap > 0 && (i % 2 == 1)) repeat (gap) @(negedge clk);
      for (int c = 0; c < 11; c++) src_row[c*8 +: 8] = 8'(src_px[i][c]);
      for (int c = 0; c < 8; c++)
        dst_row[c*8 +: 8] = (i >= 3) ? 8'(dst_px[i-3][c]) : 8'($urandom);
      if (poke && i == 5) begin
        start = 1'b1; hmode = 2'd2; vmode = 2'd2;
      end
      src_valid = 1'b1;
      acc_cyc[i] = cyc;
      @(negedge clk);
      src_valid = 1'b0;
      start = 1'b0;
    end
    repeat (4) @(negedge clk);
    check(out_tot - base == 8, req, "row count", out_tot - base, 8);
    check(done_tot - d0 == 1 && done_idx == base + 8, "R8", "done with last row",
          done_idx - base, 8);
    check(busy == 1'b0, "R8", "busy after done", busy, 0);
    for (int k = 0; k < 8; k++) begin
      logic [63:0] exp_row;
      for (int j = 0; j < 8; j++) exp_row[j*8 +: 8] = 8'(model_pix(h, v, r, a, k, j));
      check(got[(base + k) % 64] === exp_row, req, $sformatf("row %0d pixels", k),
            got[(base + k) % 64], exp_row);
      if (got_cyc[(base + k) % 64] != acc_cyc[k+3] + 2) timing_ok = 0;
    end
    check(timing_ok, "R7", "row latency", 0, 0);
  endtask

  task automatic test_zero_mode;  // R3
    int base = out_tot;
    @(negedge clk);
    hmode = 2'd0; vmode = 2'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b0, "R3", "busy after zero-mode start", busy, 0);
    for (int i = 0; i < 11; i++) begin
      src_valid = 1'b1; src_row = {$urandom, $urandom, $urandom};
      @(negedge clk);
    end
    src_valid = 1'b0;
    repeat (4) @(negedge clk);
    check(out_tot == base, "R3", "rows after zero-mode start", out_tot - base, 0);
  endtask

  task automatic test_idle_rows;  // R9
    int base = out_tot;
    int d0 = done_tot;
    for (int i = 0; i < 12; i++) begin
      src_valid = 1'b1; src_row = {$urandom, $urandom, $urandom};
      @(negedge clk);
    end
    src_valid = 1'b0;
    repeat (4) @(negedge clk);
    check(out_tot == base && done_tot == d0 && !busy, "R9", "idle rows", out_tot - base, 0);
  endtask

  initial begin
    #(150000 * 5);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !out_valid && !done, "R1", "reset state",
          {busy, out_valid, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !out_valid && !done, "R1", "after reset release",
          {busy, out_valid, done}, 0);
    // R4 R5 R11: every mode pair, both rounding settings.
    for (int h = 1; h <= 3; h++)
      for (int v = 1; v <= 3; v++)
        run_block(h, v, (h + v) % 2, 0, 0, 0, 0, "R4");
    run_block(2, 2, 1, 0, 1, 0, 0, "R5");   // flat maximum
    run_block(1, 3, 0, 0, 2, 0, 0, "R5");   // checkerboard, clips both ends
    run_block(3, 1, 1, 0, 3, 0, 0, "R5");   // column stripes
    run_block(2, 1, 1, 1, 0, 0, 0, "R6");
    run_block(3, 3, 0, 1, 2, 0, 0, "R6");
    run_block(1, 2, 0, 0, 0, 2, 0, "R7");   // gaps between rows
    run_block(3, 2, 1, 1, 0, 1, 1, "R10");  // start while busy
    run_block(1, 1, 1, 0, 0, 0, 0, "R2");
    test_zero_mode();
    test_idle_rows();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule